// File: doc/BRIEF.md
# Floating-Point Exception Stall Control

This block sits between the floating-point instruction decoder and the issue stage. For each floating-point instruction offered to it, it decides whether the instruction issues, is flagged as a numeric exception, or is held in a frozen state. The decision uses four things: whether native exception reporting is enabled, an external pin that asks for pending errors to be ignored, the summary bit showing an unmasked exception is pending, and a class code from the decoder.

A small group of control-type instructions is exempt. These include initialise, clear-exceptions, environment and state stores, status and control-word stores, and three legacy mode opcodes. They go ahead despite a pending error. Any other instruction that meets a pending error, with native reporting off and the ignore pin low, freezes the block. The block then stays frozen until an external interrupt strobe arrives. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `fpx_stall_ctrl`

## Requirements
- R1: While `native_err` is 1, the value of `ignore_err` does not change any output.
- R2: While `native_err` is 0, `ignore_err` is 1 and `pend_exc` is 1, every valid instruction of any class produces `issue_o`, including back-to-back instructions.
- R3: While `native_err` is 0, `ignore_err` is 0 and `pend_exc` is 1, a valid instruction with class code 0 through 8 (the exempt control set) produces `issue_o`.
- R4: Under the conditions of R3, a valid instruction with class code 9 through 15 produces no issue. The block enters the frozen state and `freeze_o` rises.
- R5: With `pend_exc` at 0, every valid instruction produces `issue_o`, whatever its class and whatever the control inputs.
- R6: While frozen, `freeze_o` stays at 1 until `intr_strobe` is seen. Valid instructions, the ignore pin and the pending bit produce no output while frozen.
- R7: An `intr_strobe` sampled while frozen clears `freeze_o` on the next cycle, and the held instruction is not issued.
- R8: With `native_err` at 1 and `pend_exc` at 1, a non-exempt instruction gives a one-cycle `raise_o` and no issue. An exempt instruction issues.
- R9: Outputs change exactly one clock after the sampling edge. `issue_o` and `freeze_o` are never both 1. A cycle without a valid instruction, while not frozen, gives all outputs low.
- R10: While `rst` is high and after it is released, the block is not frozen and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| native_err | input | 1 | Native numeric-error reporting enable |
| ignore_err | input | 1 | External request to ignore a pending error |
| pend_exc | input | 1 | Pending unmasked exception summary bit |
| instr_valid | input | 1 | A floating-point instruction is offered this cycle |
| instr_cls | input | 4 | Decoded class code; 0 to 8 are exempt control instructions |
| intr_strobe | input | 1 | One-cycle external interrupt strobe |
| issue_o | output | 1 | Instruction issues (registered) |
| raise_o | output | 1 | Raise numeric exception (registered pulse) |
| freeze_o | output | 1 | Block is frozen awaiting an interrupt |

## Verification
The only internal state is the frozen/running bit. If it is wrong, the ports show it on the very next clock. A block that is wrongly stuck frozen keeps `freeze_o` high and stops issuing the no-pending instructions offered after it. A block that wrongly leaves the frozen state drops `freeze_o` without a strobe, or issues a held or later instruction one cycle after the stimulus. Because of this, the scoreboard compares all three outputs every cycle after each step, and it places the release strobe both alone and together with a new instruction.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int FPX_CLS_W       = 4;
    localparam int FPX_EXEMPT_LAST = 8;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ISSUE  = 2'd1,
        ACT_RAISE  = 2'd2,
        ACT_FREEZE = 2'd3
    } fpx_act_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_FROZEN = 1'b1
    } fpx_state_e;

    typedef struct packed {
        logic native_err;
        logic ignore_err;
        logic pend_exc;
    } fpx_ctl_t;

    typedef struct packed {
        logic issue;
        logic raise;
    } fpx_out_t;

    // Per-instruction decision, independent of the frozen state.
    function automatic fpx_act_e fpx_decide(input logic valid,
                                            input logic exempt,
                                            input fpx_ctl_t ctl);
        fpx_act_e act;
        if (!valid)
            act = ACT_NONE;
        else if (!ctl.pend_exc || exempt)
            act = ACT_ISSUE;
        else if (ctl.native_err)
            act = ACT_RAISE;
        else if (ctl.ignore_err)
            act = ACT_ISSUE;
        else
            act = ACT_FREEZE;
        return act;
    endfunction

endpackage

// File: rtl/fpx_class_decode.sv
module fpx_class_decode #(
    parameter int CLS_W       = fpx_pkg::FPX_CLS_W,
    parameter int EXEMPT_LAST = fpx_pkg::FPX_EXEMPT_LAST
) (
    input  logic [CLS_W-1:0] cls,
    output logic             exempt
);
    localparam logic [CLS_W-1:0] LAST_CODE = CLS_W'(EXEMPT_LAST);

    // Exempt control instructions occupy the low codes.
    always_comb exempt = (cls <= LAST_CODE);

endmodule

// File: rtl/fpx_freeze_fsm.sv
module fpx_freeze_fsm
    import fpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fpx_act_e   act,
    input  logic       intr_strobe,
    output fpx_state_e state
);
    fpx_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (act == ACT_FREEZE) state_nx = ST_FROZEN;
            ST_FROZEN: if (intr_strobe)       state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FROZEN && !intr_strobe) |=> (state == ST_FROZEN)); // R6

    AST_STROBE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FROZEN && intr_strobe) |=> (state == ST_RUN)); // R7

endmodule

// File: rtl/fpx_out_reg.sv
module fpx_out_reg
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fpx_act_e act,
    output fpx_out_t out_q
);
    fpx_out_t out_d;

    always_comb begin
        out_d.issue = (act == ACT_ISSUE);
        out_d.raise = (act == ACT_RAISE);
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

endmodule

// File: rtl/fpx_stall_ctrl.sv
module fpx_stall_ctrl
    import fpx_pkg::*;
#(
    parameter int CLS_W       = FPX_CLS_W,
    parameter int EXEMPT_LAST = FPX_EXEMPT_LAST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             native_err,
    input  logic             ignore_err,
    input  logic             pend_exc,
    input  logic             instr_valid,
    input  logic [CLS_W-1:0] instr_cls,
    input  logic             intr_strobe,
    output logic             issue_o,
    output logic             raise_o,
    output logic             freeze_o
);
    logic       exempt;
    fpx_ctl_t   ctl;
    fpx_act_e   act_raw;
    fpx_act_e   act_eff;
    fpx_state_e state;
    fpx_out_t   out_q;

    fpx_class_decode #(.CLS_W(CLS_W), .EXEMPT_LAST(EXEMPT_LAST)) u_dec (
        .cls    (instr_cls),
        .exempt (exempt)
    );

    always_comb begin
        ctl.native_err = native_err;
        ctl.ignore_err = ignore_err;
        ctl.pend_exc   = pend_exc;
        act_raw        = fpx_decide(instr_valid, exempt, ctl);
        // A frozen block holds the offered instruction; nothing acts on it.
        act_eff        = (state == ST_RUN) ? act_raw : ACT_NONE;
    end

    fpx_freeze_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .act         (act_eff),
        .intr_strobe (intr_strobe),
        .state       (state)
    );

    fpx_out_reg u_out (
        .clk   (clk),
        .rst   (rst),
        .act   (act_eff),
        .out_q (out_q)
    );

    assign issue_o  = out_q.issue;
    assign raise_o  = out_q.raise;
    assign freeze_o = (state == ST_FROZEN);

    AST_ISSUE_FREEZE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(issue_o && freeze_o)); // R9

    AST_NO_PEND_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !pend_exc && !freeze_o) |=> issue_o); // R5

    AST_IGNORE_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && pend_exc && !native_err && ignore_err && !freeze_o) |=> issue_o); // R2

    AST_NATIVE_NEVER_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (native_err && !freeze_o) |=> !freeze_o); // R1

    AST_RELEASE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (freeze_o && intr_strobe) |=> (!freeze_o && !issue_o && !raise_o)); // R7

    AST_FROZEN_SILENT: assert property (@(posedge clk) disable iff (rst)
        freeze_o |=> (!issue_o && !raise_o)); // R6

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!issue_o && !raise_o && !freeze_o)); // R10

endmodule

// File: tb/sim_fpx_stall_ctrl.sv
`timescale 1ns/1ps
module sim_fpx_stall_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       native_err, ignore_err, pend_exc, instr_valid, intr_strobe;
    logic [3:0] instr_cls;
    logic       issue_o, raise_o, freeze_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    bit         mdl_frozen = 0;

    always #2.5 clk = ~clk;

    fpx_stall_ctrl u0 (
        .clk(clk), .rst(rst), .native_err(native_err), .ignore_err(ignore_err),
        .pend_exc(pend_exc), .instr_valid(instr_valid), .instr_cls(instr_cls),
        .intr_strobe(intr_strobe), .issue_o(issue_o), .raise_o(raise_o),
        .freeze_o(freeze_o)
    );

    // Driver: apply one cycle of stimulus and push the expected {issue,raise,freeze}.
    task automatic step(input logic v, input logic [3:0] c, input logic ne,
                        input logic ig, input logic pe, input logic it,
                        input string tag);
        logic [2:0] e;
        @(negedge clk);
        instr_valid = v; instr_cls = c; native_err = ne;
        ignore_err = ig; pend_exc = pe; intr_strobe = it;
        if (mdl_frozen) begin
            e = it ? 3'b000 : 3'b001;
            mdl_frozen = !it;
        end else if (!v) begin
            e = 3'b000;
        end else if (!pe || c <= 4'd8 || (!ne && ig)) begin
            e = 3'b100;
        end else if (ne) begin
            e = 3'b010;
        end else begin
            e = 3'b001;
            mdl_frozen = 1;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare outputs just after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({issue_o, raise_o, freeze_o} !== e) begin
                    n_fail++;
                    $display("FAIL %s: {issue,raise,freeze} actual %b expected %b",
                             t, {issue_o, raise_o, freeze_o}, e);
                end
            end
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; instr_valid = 0; instr_cls = 0; native_err = 0;
        ignore_err = 0; pend_exc = 1; intr_strobe = 0;
        repeat (3) @(negedge clk);
        instr_valid = 1; instr_cls = 4'd12;
        @(negedge clk);
        n_checks++;
        if ({issue_o, raise_o, freeze_o} !== 3'b000) begin
            n_fail++;
            $display("FAIL R10: outputs in reset actual %b expected 000",
                     {issue_o, raise_o, freeze_o});
        end
        instr_valid = 0;
        rst = 0;
        step(0, 0,  0, 0, 0, 0, "R10");
        step(0, 5,  1, 1, 1, 0, "R9");
        // R5: no pending exception
        step(1, 3,  0, 0, 0, 0, "R5");
        step(1, 12, 1, 0, 0, 0, "R5");
        step(1, 15, 0, 1, 0, 1, "R5");
        // R2: ignore pin overrides, back to back
        step(1, 12, 0, 1, 1, 0, "R2");
        step(1, 9,  0, 1, 1, 0, "R2");
        step(1, 15, 0, 1, 1, 0, "R2");
        // R3: exempt set boundaries
        step(1, 0,  0, 0, 1, 0, "R3");
        step(1, 8,  0, 0, 1, 0, "R3");
        // R8 / R1: native reporting
        step(1, 12, 1, 0, 1, 0, "R8");
        step(1, 12, 1, 1, 1, 0, "R1");
        step(1, 9,  1, 1, 1, 0, "R1");
        step(1, 5,  1, 0, 1, 0, "R8");
        step(0, 0,  1, 1, 1, 0, "R8");
        // R4: freeze on class 9
        step(1, 9,  0, 0, 1, 0, "R4");
        // R6: frozen holds
        step(1, 2,  0, 0, 0, 0, "R6");
        step(1, 12, 0, 1, 1, 0, "R6");
        step(0, 0,  1, 0, 0, 0, "R6");
        // R7: release alone
        step(0, 0,  0, 0, 1, 1, "R7");
        step(0, 0,  0, 0, 1, 0, "R9");
        step(1, 4,  0, 0, 0, 1, "R9");
        // R4 at class 15, then R7 release with an instruction offered
        step(1, 15, 0, 0, 1, 0, "R4");
        step(1, 3,  0, 0, 0, 1, "R7");
        step(1, 3,  0, 0, 0, 0, "R5");
        step(0, 0,  0, 0, 0, 0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule